// File: doc/BRIEF.md
# Clipped Delta Counter Output Unit

This unit converts a stream of sample bytes into a 7-bit code for a digital-to-analog converter. Each byte is serialized one bit per bit-rate tick, least significant bit first. Each serialized bit moves a 6-bit level counter up by one for a 1 or down by one for a 0. The counter stops at its limits rather than wrapping. The six counter bits form the upper part of the output code. The lowest output bit is a separate flop.

A direct-load write port sets the counter and the separate low bit in one step, so software can also drive the output as plain 7-bit PCM. A byte that arrives while serialization is in progress waits in a one-byte holding register. It starts once the current eight bits have all been consumed. The bit-rate tick comes from an outside timer that runs at eight times the byte rate.

Top module: `delta_dac_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `dac_code` is 0 and `shift_empty` is 1.
- R2: The bits of a serialized byte are applied starting with bit 0, then bit 1, and so on up to bit 7, one bit per `bit_tick` pulse.
- R3: An applied 1 adds one to the 6-bit level and an applied 0 subtracts one. The level occupies `dac_code[6:1]`, and the change is visible on the cycle after the tick.
- R4: A 0 applied at level 0 leaves the level at 0. A 1 applied at level 63 leaves it at 63. There is no wrap in either direction.
- R5: A `load_we` cycle sets `dac_code[6:1]` from `load_data[6:1]` and `dac_code[0]` from `load_data[0]`, visible on the next cycle. `load_data[7]` has no effect.
- R6: `dac_code[0]` changes only on a `load_we` cycle. Bit stepping never alters it.
- R7: When no bits are pending, `bit_tick` leaves the level unchanged. `shift_empty` is 1 exactly when no bits are pending and no byte is held.
- R8: `byte_valid` stores `byte_data` in the holding register, and `shift_empty` reads 0 on the next cycle. When the serializer has no bits pending, the held byte moves into the serializer one cycle later. A byte received during serialization waits until all eight current bits are consumed. A newer byte overwrites an older byte that is still held.
- R9: When `load_we` and `bit_tick` occur in the same cycle, the load sets the level. The pending bit is still consumed and does not step the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Strobe: `byte_data` holds a new sample byte |
| byte_data | input | 8 | Sample byte to serialize |
| bit_tick | input | 1 | One-cycle pulse at the bit rate |
| load_we | input | 1 | Direct-load write strobe |
| load_data | input | 8 | Direct-load value; bits 6:1 set the level, bit 0 sets the output low bit |
| dac_code | output | 7 | Converter code: level in bits 6:1, separate low bit in bit 0 |
| shift_empty | output | 1 | No bits pending and no byte held |

## Verification
Latency matters in three places:
- A byte strobed while the serializer is idle moves into the holding register on the first edge and into the serializer on the second. The bench therefore waits two cycles before its first tick.
- A tick or a direct load shows on `dac_code` one edge later. The bench drives each stimulus on a falling edge and reads the result on the next falling edge.
- Each tick is followed by one idle cycle. This lets a held byte move into the serializer before the next tick. The buffer test relies on that slot and expects the second byte's bits with no extra wait.

// File: rtl/delta_dac_unit.sv
module delta_dac_unit #(
  parameter int CW = 6,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [BW-1:0] byte_data,
  input  logic          bit_tick,
  input  logic          load_we,
  input  logic [CW+1:0] load_data,
  output logic [CW:0]   dac_code,
  output logic          shift_empty
);
  localparam int NW = $clog2(BW + 1);
  localparam logic [CW-1:0] CMAX = '1;

  logic [BW-1:0] sreg, hold;
  logic          hold_full;
  logic [NW-1:0] left;
  logic [CW-1:0] level;
  logic          lsb;

  wire active = (left != '0);
  wire step   = bit_tick && active;
  wire refill = !active && hold_full;
  wire unused_top = load_data[CW+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg      <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      left      <= '0;
      level     <= '0;
      lsb       <= 1'b0;
    end else begin
      if (byte_valid) hold <= byte_data;
      if (byte_valid) hold_full <= 1'b1;
      else if (refill) hold_full <= 1'b0;

      if (refill) begin
        sreg <= hold;
        left <= NW'(BW);
      end else if (step) begin
        sreg <= sreg >> 1;
        left <= left - 1'b1;
      end

      if (load_we) begin
        level <= load_data[CW:1];
        lsb   <= load_data[0];
      end else if (step) begin
        if (sreg[0] && level != CMAX) level <= level + 1'b1;
        else if (!sreg[0] && level != '0) level <= level - 1'b1;
      end
    end
  end

  assign dac_code    = {level, lsb};
  assign shift_empty = !active && !hold_full;

  a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_we) && $past(level) == '0) |-> level != CMAX);
  a_r4_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_we) && $past(level) == CMAX) |-> level != '0);
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_we) |-> dac_code == $past(load_data[CW:0]));
  a_r6_lsb_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_we) |-> $stable(dac_code[0]));
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_we) && !$past(active)) |-> $stable(level));
  a_r8_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $past(byte_valid) |-> !shift_empty);
endmodule

// File: tb/delta_dac_unit_tb.sv
`timescale 1ns/1ps
module delta_dac_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_valid = 1'b0, bit_tick = 1'b0, load_we = 1'b0;
  logic [7:0] byte_data = '0, load_data = '0;
  logic [6:0] dac_code;
  logic shift_empty;
  int n_chk = 0, n_fail = 0;
  logic [5:0] m_lvl = '0;
  logic m_lsb = 1'b0;

  always #2.5 clk = ~clk;

  delta_dac_unit u_dut (.clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
    .byte_data(byte_data), .bit_tick(bit_tick), .load_we(load_we),
    .load_data(load_data), .dac_code(dac_code), .shift_empty(shift_empty));

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model_step(input logic b);
    if (b && m_lvl != 6'd63) m_lvl = m_lvl + 1'b1;
    else if (!b && m_lvl != 6'd0) m_lvl = m_lvl - 1'b1;
  endtask

  task automatic tick_bit(input logic b, input string tag);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    model_step(b);
    check(tag, dac_code, {m_lvl, m_lsb});
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    byte_valid = 1'b1; byte_data = b;
    @(negedge clk);
    byte_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic play(input logic [7:0] b, input string tag);
    send_byte(b);
    for (int i = 0; i < 8; i++) tick_bit(b[i], tag);
  endtask

  task automatic direct(input logic [7:0] d, input string tag);
    load_we = 1'b1; load_data = d;
    @(negedge clk);
    load_we = 1'b0;
    m_lvl = d[6:1]; m_lsb = d[0];
    check(tag, dac_code, {m_lvl, m_lsb});
  endtask

  task automatic t_reset;
    check("R1 code in reset", dac_code, 0);
    check("R1 empty in reset", shift_empty, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 code after reset", dac_code, 0);
    check("R1 empty after reset", shift_empty, 1);
  endtask

  task automatic t_rise;
    play(8'hFF, "R3 rising steps");
    check("R3 level after 0xFF", dac_code, 16);
    check("R7 empty after byte", shift_empty, 1);
  endtask

  task automatic t_order;
    direct(8'h40, "R5 load 0x40");
    play(8'hA5, "R2 lsb-first 0xA5");
    play(8'h3C, "R2 lsb-first 0x3C");
  endtask

  task automatic t_clip;
    direct(8'h7E, "R5 load 0x7E");
    play(8'hFF, "R4 ceiling hold");
    check("R4 ceiling final", dac_code, 7'h7E);
    direct(8'h01, "R5 load 0x01");
    play(8'h00, "R4 floor hold / R6 lsb kept");
    check("R6 lsb after stepping", dac_code, 1);
  endtask

  task automatic t_msb_ignored;
    direct(8'h80, "R5 bit7 ignored");
    check("R5 bit7 ignored value", dac_code, 0);
    direct(8'hD3, "R5 bit7 ignored 0xD3");
  endtask

  task automatic t_idle;
    direct(8'h2B, "R5 load 0x2B");
    for (int i = 0; i < 3; i++) tick_bit(1'b0, "R7 idle tick");
  endtask

  task automatic t_idle_fix;
    // ticks while idle must not step: the model is restored for the expected value
    direct(8'h2B, "R5 load 0x2B");
    for (int i = 0; i < 3; i++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      check("R7 idle tick holds", dac_code, 7'h2B);
      check("R7 idle empty", shift_empty, 1);
      @(negedge clk);
    end
  endtask

  task automatic t_buffer;
    direct(8'h40, "R5 load 0x40");
    send_byte(8'hFF);
    for (int i = 0; i < 3; i++) tick_bit(1'b1, "R8 first byte");
    send_byte(8'h00);
    check("R8 held byte not empty", shift_empty, 0);
    for (int i = 3; i < 8; i++) tick_bit(1'b1, "R8 first byte tail");
    check("R8 second byte queued", shift_empty, 0);
    for (int i = 0; i < 8; i++) tick_bit(1'b0, "R8 second byte");
    check("R8 level after both", dac_code, 7'h40);
    check("R8 empty after both", shift_empty, 1);
  endtask

  task automatic t_priority;
    logic [7:0] b;
    b = 8'hF0;
    send_byte(b);
    bit_tick = 1'b1; load_we = 1'b1; load_data = 8'h2A;
    @(negedge clk);
    bit_tick = 1'b0; load_we = 1'b0;
    m_lvl = 6'd21; m_lsb = 1'b0;
    check("R9 load wins", dac_code, 7'h2A);
    @(negedge clk);
    for (int i = 1; i < 8; i++) tick_bit(b[i], "R9 bit consumed");
    check("R9 final level", dac_code, 22 << 1);
    check("R9 empty", shift_empty, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_rise();
    t_order();
    t_clip();
    t_msb_ignored();
    t_idle_fix();
    t_buffer();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule